// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Register File

This block is the software-facing register file of one DMA channel. A host reaches it through a simple word-addressed bus: a request strobe with a write enable, a 5-bit word address and 32-bit write data. Read data is combinational from the address. The registers cover identification, a scratch word, control (enable, pause), transfer flags, interrupt mask, pending and source, and a submission handshake that hands transfer descriptors to the datapath.

Software writes 1 to the submit register. The block then raises a descriptor-valid toward the data movers, tagged with a hardware-assigned 2-bit rolling ID. At most four transfers can be outstanding at once. The data movers return completion pulses carrying an ID, in submission order. A per-ID done bitmap records which transfers have finished, and the active-ID register names the oldest unfinished transfer.

The two interrupt events are "transfer queued" and "transfer completed". Each has a source bit that records the raw event and a pending bit that is gated by the mask. Pending bits are write-1-to-clear, and clearing a pending bit also clears its source bit. The interrupt output is the OR of the pending bits.

Top module: `dma_ctrl_regs`

## Requirements
- R1: Word 0x00 reads the constant 0x444D4143. Word 0x01 reads the version, with major in [31:16], minor in [15:8] and patch in [7:0] (defaults 4, 2, 0x61). Word 0x02 is a 32-bit read/write scratch word that resets to 0.
- R2: Word 0x04 is the interrupt mask: bit 1 masks "completed" and bit 0 masks "queued". Both bits reset to 1. A pending bit sets only when its event occurs while its mask bit is 0.
- R3: Word 0x06 holds the source bits (bit 1 completed, bit 0 queued). They set on every event regardless of the mask and are read-only.
- R4: Word 0x05 holds the pending bits, with the same bit positions. Writing 1 to a bit clears that pending bit and the matching source bit in the same cycle. Writing 0 to a bit leaves it unchanged.
- R5: Writing 1 to bit 0 of word 0x0A while enabled sets submit. Submit drives desc_valid_o, and the submit bit reads back 0 after the cycle in which desc_valid_o and desc_ready_i are both high. Writing 0 to it has no effect.
- R6: Word 0x08 is control: bit 0 enable, bit 1 pause, both reset to 0. While enable is 0, submit reads 0 and writes of 1 to submit are ignored.
- R7: Word 0x09 reads the next transfer ID in bits [1:0], starting at 0. desc_id_o carries this ID. Each accepted descriptor advances it by 1, modulo 4.
- R8: Word 0x0C is the done bitmap: bit x clears when ID x is accepted and sets on a completion pulse for ID x. It resets to 0.
- R9: Word 0x0D reads the oldest outstanding ID, or the next ID when no transfer is outstanding.
- R10: With four transfers outstanding, desc_valid_o stays 0 and submit stays 1 until a completion frees an ID.
- R11: Word 0x0B bit 0 selects cyclic mode and bit 1 selects end-of-transfer marking (reset 0 and 1); both drive the descriptor outputs. A completion of a descriptor queued in cyclic mode updates the done bitmap but raises no completed event.
- R12: irq_o is the OR of the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| ctrl_enable_o | output | 1 | Channel enable |
| ctrl_pause_o | output | 1 | Channel pause |
| desc_valid_o | output | 1 | Descriptor offered to datapath |
| desc_ready_i | input | 1 | Datapath accepts descriptor |
| desc_id_o | output | 2 | ID of offered descriptor |
| desc_cyclic_o | output | 1 | Descriptor is cyclic |
| desc_last_o | output | 1 | Mark end of transfer |
| cpl_valid_i | input | 1 | Completion pulse |
| cpl_id_i | input | 2 | ID of completed transfer |
| irq_o | output | 1 | Interrupt request |

## Verification
The ID bookkeeping is driven by a seeded random mix of accept and completion operations. This mix separates errors in ID wrap-around, in selecting the oldest outstanding ID, and in per-ID done bits that are cleared or set at the wrong time. Directed cases cover the boundaries: a full queue holding submit high, disable dropping submit, a write of 0 to submit, and a cyclic completion that updates done without an event. Interrupt checks run with each mask setting and clear each pending bit separately. These cases show whether a mask gates only pending or also source, and whether write-1-to-clear reaches the source bit.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int IRQ_N  = 2;
  localparam int IRQ_QUEUED = 0;
  localparam int IRQ_DONE   = 1;
  localparam logic [DATA_W-1:0] IDENT_VAL = 32'h444D_4143;

  typedef enum logic [ADDR_W-1:0] {
    A_IDENT   = 5'h00,
    A_VERSION = 5'h01,
    A_SCRATCH = 5'h02,
    A_MASK    = 5'h04,
    A_PEND    = 5'h05,
    A_SRC     = 5'h06,
    A_CTRL    = 5'h08,
    A_NEXT_ID = 5'h09,
    A_SUBMIT  = 5'h0A,
    A_FLAGS   = 5'h0B,
    A_DONE    = 5'h0C,
    A_ACTIVE  = 5'h0D
  } reg_addr_e;
endpackage

// File: rtl/dma_irq_unit.sv
module dma_irq_unit #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] event_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] src_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic pend_q, src_q;
    // a new event wins over a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= 1'b0;
        src_q  <= 1'b0;
      end else begin
        if (event_i[i]) begin
          src_q <= 1'b1;
          if (!mask_i[i]) pend_q <= 1'b1;
          else if (clr_i[i]) pend_q <= 1'b0;
        end else if (clr_i[i]) begin
          src_q  <= 1'b0;
          pend_q <= 1'b0;
        end
      end
    end
    assign pend_o[i] = pend_q;
    assign src_o[i]  = src_q;
  end
endmodule

// File: rtl/dma_id_tracker.sv
module dma_id_tracker #(
  parameter int ID_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 queue_i,
  input  logic                 queue_cyc_i,
  input  logic                 retire_i,
  input  logic [ID_W-1:0]      retire_id_i,
  output logic [ID_W-1:0]      next_id_o,
  output logic [ID_W-1:0]      active_id_o,
  output logic                 full_o,
  output logic                 empty_o,
  output logic                 retire_cyc_o,
  output logic [(1<<ID_W)-1:0] done_o
);
  localparam int NUM_IDS = 1 << ID_W;
  localparam int CNT_W   = ID_W + 1;

  logic [ID_W-1:0]    head_q, tail_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_IDS-1:0] done_q, cyc_q;

  assign full_o  = (cnt_q == CNT_W'(NUM_IDS));
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (queue_i) head_q <= head_q + 1'b1;
      if (retire_i) tail_q <= tail_q + 1'b1;
      case ({queue_i, retire_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        done_q[i] <= 1'b0;
        cyc_q[i]  <= 1'b0;
      end else if (queue_i && head_q == ID_W'(i)) begin
        done_q[i] <= 1'b0;
        cyc_q[i]  <= queue_cyc_i;
      end else if (retire_i && retire_id_i == ID_W'(i)) begin
        done_q[i] <= 1'b1;
      end
    end
  end

  assign next_id_o    = head_q;
  assign active_id_o  = empty_o ? head_q : tail_q;
  assign retire_cyc_o = cyc_q[retire_id_i];
  assign done_o       = done_q;
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_regs_pkg::*;
#(
  parameter int ID_W      = 2,
  parameter int VER_MAJOR = 4,
  parameter int VER_MINOR = 2,
  parameter int VER_PATCH = 'h61
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ctrl_enable_o,
  output logic              ctrl_pause_o,
  output logic              desc_valid_o,
  input  logic              desc_ready_i,
  output logic [ID_W-1:0]   desc_id_o,
  output logic              desc_cyclic_o,
  output logic              desc_last_o,
  input  logic              cpl_valid_i,
  input  logic [ID_W-1:0]   cpl_id_i,
  output logic              irq_o
);
  localparam int NUM_IDS = 1 << ID_W;

  logic              wr;
  logic [DATA_W-1:0] scratch_q;
  logic [IRQ_N-1:0]  mask_q, pend, src, irq_evt, irq_clr;
  logic              enable_q, pause_q, cyclic_q, last_q, submit_q;
  logic              hs, retire, retire_cyc, full, empty;
  logic [ID_W-1:0]   next_id, active_id;
  logic [NUM_IDS-1:0] done;

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q <= '0;
      mask_q    <= '1;
      enable_q  <= 1'b0;
      pause_q   <= 1'b0;
      cyclic_q  <= 1'b0;
      last_q    <= 1'b1;
    end else if (wr) begin
      case (addr_i)
        A_SCRATCH: scratch_q <= wdata_i;
        A_MASK:    mask_q    <= wdata_i[IRQ_N-1:0];
        A_CTRL:    {pause_q, enable_q} <= wdata_i[1:0];
        A_FLAGS:   {last_q, cyclic_q}  <= wdata_i[1:0];
        default: ;
      endcase
    end
  end

  // submit handshake: set by software, cleared on accept or disable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) submit_q <= 1'b0;
    else if (!enable_q) submit_q <= 1'b0;
    else if (wr && addr_i == A_SUBMIT && wdata_i[0]) submit_q <= 1'b1;
    else if (hs) submit_q <= 1'b0;
  end

  assign desc_valid_o = submit_q & enable_q & ~full;
  assign hs           = desc_valid_o & desc_ready_i;
  assign retire       = cpl_valid_i & ~empty;

  dma_id_tracker #(.ID_W(ID_W)) u_ids (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .queue_i      (hs),
    .queue_cyc_i  (cyclic_q),
    .retire_i     (retire),
    .retire_id_i  (cpl_id_i),
    .next_id_o    (next_id),
    .active_id_o  (active_id),
    .full_o       (full),
    .empty_o      (empty),
    .retire_cyc_o (retire_cyc),
    .done_o       (done)
  );

  always_comb begin
    irq_evt = '0;
    irq_evt[IRQ_QUEUED] = hs;
    irq_evt[IRQ_DONE]   = retire & ~retire_cyc;
  end
  assign irq_clr = (wr && addr_i == A_PEND) ? wdata_i[IRQ_N-1:0] : '0;

  dma_irq_unit #(.N(IRQ_N)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (irq_evt),
    .mask_i  (mask_q),
    .clr_i   (irq_clr),
    .pend_o  (pend),
    .src_o   (src)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_IDENT:   rdata_o = IDENT_VAL;
      A_VERSION: rdata_o = {16'(VER_MAJOR), 8'(VER_MINOR), 8'(VER_PATCH)};
      A_SCRATCH: rdata_o = scratch_q;
      A_MASK:    rdata_o[IRQ_N-1:0] = mask_q;
      A_PEND:    rdata_o[IRQ_N-1:0] = pend;
      A_SRC:     rdata_o[IRQ_N-1:0] = src;
      A_CTRL:    rdata_o[1:0] = {pause_q, enable_q};
      A_NEXT_ID: rdata_o[ID_W-1:0] = next_id;
      A_SUBMIT:  rdata_o[0] = submit_q;
      A_FLAGS:   rdata_o[1:0] = {last_q, cyclic_q};
      A_DONE:    rdata_o[NUM_IDS-1:0] = done;
      A_ACTIVE:  rdata_o[ID_W-1:0] = active_id;
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_enable_o = enable_q;
  assign ctrl_pause_o  = pause_q;
  assign desc_id_o     = next_id;
  assign desc_cyclic_o = cyclic_q;
  assign desc_last_o   = last_q;
  assign irq_o         = |pend;
endmodule

// File: rtl/dma_ctrl_regs_chk.sv
module dma_ctrl_regs_chk #(
  parameter int ID_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            desc_valid_o,
  input logic            desc_ready_i,
  input logic            ctrl_enable_o,
  input logic            submit_q,
  input logic            full,
  input logic            empty,
  input logic [1:0]      mask_q,
  input logic [1:0]      pend,
  input logic [1:0]      src,
  input logic [ID_W-1:0] next_id,
  input logic [ID_W-1:0] active_id,
  input logic            wr_submit
);
  // R5
  submit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && desc_ready_i && !wr_submit) |=> !submit_q);
  // R6
  disable_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_enable_o |=> !submit_q);
  // R10
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !desc_valid_o);
  // R4
  pend_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend & ~src) == 2'b00);
  // R2
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend[0]) |-> !$past(mask_q[0]));
  // R9
  idle_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> (active_id == next_id));
endmodule

bind dma_ctrl_regs dma_ctrl_regs_chk #(.ID_W(ID_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .desc_valid_o  (desc_valid_o),
  .desc_ready_i  (desc_ready_i),
  .ctrl_enable_o (ctrl_enable_o),
  .submit_q      (submit_q),
  .full          (full),
  .empty         (empty),
  .mask_q        (mask_q),
  .pend          (pend),
  .src           (src),
  .next_id       (next_id),
  .active_id     (active_id),
  .wr_submit     (wr && addr_i == dma_regs_pkg::A_SUBMIT && wdata_i[0])
);

// File: tb/dma_ctrl_regs_tb.sv
module dma_ctrl_regs_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        en_o, pause_o, dv, dr = 1'b0, dcyc, dlast, cv = 1'b0, irq;
  logic [1:0]  did, cid = '0;
  int n_chk = 0, n_bad = 0;

  // bench model
  int       m_next = 0, m_tail = 0, m_out = 0;
  bit [3:0] m_done = '0, m_cyc = '0;
  bit [1:0] m_mask = 2'b11, m_src = '0, m_pend = '0;
  bit       m_cycmode = 0;

  always #10 clk = ~clk;

  dma_ctrl_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ctrl_enable_o(en_o), .ctrl_pause_o(pause_o),
    .desc_valid_o(dv), .desc_ready_i(dr), .desc_id_o(did), .desc_cyclic_o(dcyc),
    .desc_last_o(dlast), .cpl_valid_i(cv), .cpl_id_i(cid), .irq_o(irq)
  );

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  function automatic bit [1:0] gate(bit [1:0] evt);
    return evt & ~m_mask;
  endfunction

  task automatic submit_accept(string tag);
    wr(5'h0A, 1);
    #1; chk({tag, " R5 valid"}, dv, 1);
    chk({tag, " R7 desc_id"}, did, m_next[1:0]);
    dr = 1; @(negedge clk); dr = 0;
    m_done[m_next] = 0; m_cyc[m_next] = m_cycmode;
    m_next = (m_next + 1) % 4; m_out++;
    m_src[0] = 1; m_pend |= gate(2'b01);
  endtask

  task automatic complete(string tag);
    @(negedge clk); cv = 1; cid = m_tail[1:0];
    @(negedge clk); cv = 0;
    m_done[m_tail] = 1;
    if (!m_cyc[m_tail]) begin m_src[1] = 1; m_pend |= gate(2'b10); end
    m_tail = (m_tail + 1) % 4; m_out--;
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    rd(5'h09, d); chk({tag, " R7 next_id"}, d, m_next);
    rd(5'h0D, d); chk({tag, " R9 active"}, d, (m_out == 0) ? m_next : m_tail);
    rd(5'h0C, d); chk({tag, " R8 done"}, d, {28'd0, m_done});
    rd(5'h06, d); chk({tag, " R3 src"}, d, {30'd0, m_src});
    rd(5'h05, d); chk({tag, " R4 pend"}, d, {30'd0, m_pend});
    chk({tag, " R12 irq"}, irq, |m_pend);
  endtask

  task automatic clr_pend(bit [1:0] b);
    wr(5'h05, {30'd0, b});
    m_pend &= ~b; m_src &= ~b;
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(5'h00, d); chk("R1 ident", d, 32'h444D4143);
    rd(5'h01, d); chk("R1 version", d, 32'h0004_0261);
    rd(5'h02, d); chk("R1 scratch reset", d, 0);
    rd(5'h04, d); chk("R2 mask reset", d, 3);
    rd(5'h08, d); chk("R6 ctrl reset", d, 0);
    rd(5'h0B, d); chk("R11 flags reset", d, 2);
    check_all("reset");
    wr(5'h02, 32'hA5C3_0F96); rd(5'h02, d); chk("R1 scratch rw", d, 32'hA5C3_0F96);

    // R6: submit ignored while disabled
    wr(5'h0A, 1); rd(5'h0A, d); chk("R6 submit while disabled", d, 0);
    #1; chk("R6 no valid while disabled", dv, 0);
    wr(5'h08, 3); #1; chk("R6 enable/pause out", {pause_o, en_o}, 2'b11);
    wr(5'h08, 1);

    // R2/R3: masked queued event sets source only
    submit_accept("masked");
    rd(5'h0A, d); chk("R5 submit self-clear", d, 0);
    check_all("masked");
    clr_pend(2'b01); check_all("R4 clr src");

    // R5: writing 0 has no effect
    wr(5'h0A, 1); wr(5'h0A, 0);
    rd(5'h0A, d); chk("R5 write0 keeps submit", d, 1);
    // R6: disable drops pending submit
    wr(5'h08, 0); rd(5'h0A, d); chk("R6 disable clears submit", d, 0);
    wr(5'h08, 1);

    // unmask both
    wr(5'h04, 0); m_mask = 2'b00;
    submit_accept("unmasked");
    check_all("R2 unmasked queued");
    complete("c1"); complete("c2");
    check_all("R8 done after cpl");
    clr_pend(2'b10); check_all("R4 clr done only");
    clr_pend(2'b01); check_all("R12 irq low");

    // R10: fill four
    for (int i = 0; i < 4; i++) submit_accept("fill");
    wr(5'h0A, 1);
    #1; chk("R10 full no valid", dv, 0);
    rd(5'h0A, d); chk("R10 submit held", d, 1);
    check_all("R10 full");
    complete("free");
    #1; chk("R10 valid after free", dv, 1);
    dr = 1; @(negedge clk); dr = 0;
    m_done[m_next] = 0; m_cyc[m_next] = 0; m_next = (m_next + 1) % 4; m_out++;
    m_src[0] = 1; m_pend |= gate(2'b01);
    check_all("R10 after refill");
    while (m_out > 0) complete("drain");
    clr_pend(2'b11); check_all("drained");

    // R11: cyclic completion raises no event
    wr(5'h0B, 1); #1; chk("R11 cyclic out", {dlast, dcyc}, 2'b01);
    m_cycmode = 1;
    submit_accept("cyc");
    clr_pend(2'b01);
    complete("cyc");
    check_all("R11 cyclic no event");
    wr(5'h0B, 2); m_cycmode = 0;

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 5 && m_out < 4) submit_accept("rnd");
      else if (op < 9 && m_out > 0) complete("rnd");
      else begin
        bit [1:0] b = 2'($urandom_range(0, 3));
        clr_pend(b);
      end
      if (it % 5 == 0) begin
        bit [1:0] mk = 2'($urandom_range(0, 3));
        wr(5'h04, {30'd0, mk}); m_mask = mk;
      end
      check_all("rnd");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule